// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Test Access

This block holds the two character queues of a 16550-style serial port. In normal operation the host writes bytes into the transmit queue, and a serializer drains it one byte at a time through a pop handshake. A deserializer pushes each received byte into the receive queue, together with a parity-error flag and a framing-error flag, and the host reads the bytes back through the data register. The error flags of the oldest received byte appear in the status register.

A test-access mode disconnects both queues from the serial side. The serializer can no longer pop the transmit queue, and deserializer pushes are dropped. The host can then read the transmit queue head through a peek register, which also pops it. It can also inject receive entries that carry arbitrary error flags. Every change of the test-access enable empties both queues. All register accesses take one clock cycle, and read data appears registered on the following cycle.

Top module: `uart_fifo_pair`

## Requirements
- R1: The transmit queue holds DEPTH bytes in first-in first-out order, and a host write to address 0 while it is full is dropped without disturbing stored bytes.
- R2: In normal mode `ser_avail` is high exactly when the transmit queue holds data, `ser_pop_data` shows the oldest byte, and a cycle with `ser_pop_req` high removes that byte.
- R3: In normal mode a `des_push` cycle stores `des_data` with `des_perr` and `des_ferr`; a read of address 0 returns the oldest data byte in bits 7:0 with bits 9:8 zero and removes the entry.
- R4: A read of address 1 returns bit 0 = receive data present, bit 1 = parity flag of the oldest receive entry, bit 2 = framing flag of that entry, bit 3 = transmit queue empty, and all other bits zero; bits 1 and 2 read zero when the receive queue is empty.
- R5: Bit 0 of address 2 is the test-access enable and reads back its value. A write to address 2 that changes the enable empties both queues, and a write that leaves it unchanged does not.
- R6: In test-access mode `ser_avail` stays low, `ser_pop_req` removes nothing, and host writes to address 0 still fill the transmit queue.
- R7: A read of address 3 returns the transmit queue head (zero when empty). It removes that byte only in test-access mode.
- R8: In test-access mode `des_push` is ignored, and a write to address 4 stores an entry with data = bits 7:0, parity flag = bit 8 and framing flag = bit 9. In normal mode a write to address 4 is ignored.
- R9: A read of address 0 on an empty receive queue returns zero and changes nothing, and pushes into a full receive queue are dropped.
- R10: `bus_rdata` changes only on the cycle after a read and holds its value otherwise; it is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address (0 data, 1 status, 2 test enable, 3 transmit peek, 4 receive inject) |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Registered read data |
| ser_pop_req | input | 1 | Serializer takes the head byte |
| ser_avail | output | 1 | Transmit byte available to serializer |
| ser_pop_data | output | 8 | Transmit queue head byte |
| des_push | input | 1 | Deserializer delivers a byte |
| des_data | input | 8 | Received byte |
| des_perr | input | 1 | Parity error for received byte |
| des_ferr | input | 1 | Framing error for received byte |

## Verification
The bench builds the block with DEPTH = 8 instead of 128. With this setting, both queues can be filled to capacity and overrun within a few dozen cycles. Dropped writes at the full boundary, pointer wraparound and the empty-read cases are all exercised alongside the mode switches. All read results pass through a scoreboard queue ordered by issue.

// File: rtl/ufq_pkg.sv
package ufq_pkg;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = 10;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 3'd0,
    A_STAT = 3'd1,
    A_TEST = 3'd2,
    A_PEEK = 3'd3,
    A_INJ  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [BYTE_W-1:0] data;
  } rx_ent_t;
endpackage

// File: rtl/ufq_fifo.sv
module ufq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R1: occupancy never exceeds capacity
  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R1/R9: push into full without pop leaves it full
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop && !clr |=> full);
  // R9: pop on empty without push leaves it empty
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push |=> empty);
  // R5: clear empties the queue
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/ufq_regif.sv
module ufq_regif
  import ufq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [BYTE_W-1:0] tx_head,
  input  logic              tx_empty,
  input  rx_ent_t           rx_head,
  input  logic              rx_empty,
  output logic              test_mode,
  output logic              fifo_clr,
  output logic              tx_bus_push,
  output logic              tx_bus_pop,
  output logic              rx_bus_pop,
  output logic              rx_inj_push,
  output rx_ent_t           rx_inj_data
);
  logic wr_cyc, rd_cyc, wr_test;

  assign wr_cyc      = bus_sel && bus_wr;
  assign rd_cyc      = bus_sel && !bus_wr;
  assign wr_test     = wr_cyc && (bus_addr == A_TEST);
  assign fifo_clr    = wr_test && (bus_wdata[0] != test_mode);
  assign tx_bus_push = wr_cyc && (bus_addr == A_DATA);
  assign tx_bus_pop  = rd_cyc && (bus_addr == A_PEEK) && test_mode;
  assign rx_bus_pop  = rd_cyc && (bus_addr == A_DATA);
  assign rx_inj_push = wr_cyc && (bus_addr == A_INJ) && test_mode;
  assign rx_inj_data = rx_ent_t'(bus_wdata);

  always_ff @(posedge clk) begin
    if (rst) test_mode <= 1'b0;
    else if (wr_test) test_mode <= bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_cyc) begin
      case (bus_addr)
        A_DATA:  bus_rdata <= rx_empty ? '0 : BUS_W'(rx_head.data);
        A_STAT:  bus_rdata <= BUS_W'({tx_empty,
                                      rx_head.ferr && !rx_empty,
                                      rx_head.perr && !rx_empty,
                                      !rx_empty});
        A_TEST:  bus_rdata <= BUS_W'(test_mode);
        A_PEEK:  bus_rdata <= tx_empty ? '0 : BUS_W'(tx_head);
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R5: enable bit follows the written value
  p_mode_readback_r5: assert property (@(posedge clk) disable iff (rst)
    wr_test |=> test_mode == $past(bus_wdata[0]));
  // R10: read data holds between reads
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_cyc |=> $stable(bus_rdata));
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import ufq_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ser_pop_req,
  output logic              ser_avail,
  output logic [BYTE_W-1:0] ser_pop_data,
  input  logic              des_push,
  input  logic [BYTE_W-1:0] des_data,
  input  logic              des_perr,
  input  logic              des_ferr
);
  localparam int RX_W = $bits(rx_ent_t);

  logic          test_mode, fifo_clr;
  logic          tx_bus_push, tx_bus_pop, rx_bus_pop, rx_inj_push;
  rx_ent_t       rx_inj_data, rx_din, rx_head;
  logic [BYTE_W-1:0] tx_head;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic          tx_pop, rx_push;

  ufq_regif u_regif (
    .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .tx_head, .tx_empty, .rx_head, .rx_empty,
    .test_mode, .fifo_clr, .tx_bus_push, .tx_bus_pop, .rx_bus_pop,
    .rx_inj_push, .rx_inj_data
  );

  assign tx_pop  = tx_bus_pop || (ser_pop_req && !test_mode);
  assign rx_push = test_mode ? rx_inj_push : des_push;
  assign rx_din  = test_mode ? rx_inj_data
                             : rx_ent_t'{ferr: des_ferr, perr: des_perr, data: des_data};

  ufq_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_tx (
    .clk, .rst, .clr(fifo_clr), .push(tx_bus_push), .din(bus_wdata[BYTE_W-1:0]),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  ufq_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rx (
    .clk, .rst, .clr(fifo_clr), .push(rx_push), .din(rx_din),
    .pop(rx_bus_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  assign ser_avail    = !tx_empty && !test_mode;
  assign ser_pop_data = tx_head;

  // R6: serializer cannot drain the queue in test-access mode
  p_tx_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    test_mode && !tx_empty && ser_pop_req && !tx_bus_pop && !fifo_clr |=> !tx_empty);
  // R8: deserializer cannot fill the queue in test-access mode
  p_rx_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    test_mode && rx_empty && des_push && !rx_inj_push && !fifo_clr |=> rx_empty);
  // R5: a mode change leaves both queues empty
  p_mode_clears_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> tx_empty && rx_empty && !ser_avail);
  // R9: a full receive queue stays full when only pushes arrive
  p_rx_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    rx_full && !rx_bus_pop && !fifo_clr |=> rx_full);
endmodule

// File: tb/uart_fifo_pair_test.sv
module uart_fifo_pair_test;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [9:0] bus_wdata = 0;
  logic [9:0] bus_rdata;
  logic       ser_pop_req = 0, ser_avail;
  logic [7:0] ser_pop_data;
  logic       des_push = 0, des_perr = 0, des_ferr = 0;
  logic [7:0] des_data = 0;

  int n_chk = 0, n_bad = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #10 clk = ~clk;

  uart_fifo_pair #(.DEPTH(DEPTH)) uut (.*);

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each read result with the scoreboard head
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr && !rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R10 unexpected read", bus_rdata, 10'h3ff);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic drive(input logic s, w, input logic [2:0] a, input logic [9:0] d,
                       input logic sp, dp, input logic [7:0] dd, input logic pe, fe);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    ser_pop_req = sp; des_push = dp; des_data = dd; des_perr = pe; des_ferr = fe;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic bwr(input logic [2:0] a, input logic [9:0] d);
    drive(1, 1, a, d, 0, 0, 0, 0, 0);
  endtask
  task automatic brd(input logic [2:0] a, input logic [9:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    drive(1, 0, a, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic spop();
    drive(0, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask
  task automatic dpush(input logic [7:0] d, input logic pe, fe);
    drive(0, 0, 0, 0, 0, 1, d, pe, fe);
  endtask
  task automatic chk_ser(input logic av, input logic [7:0] d, input string tag);
    check({tag, " avail"}, 10'(ser_avail), 10'(av));
    if (av) check({tag, " data"}, 10'(ser_pop_data), 10'(d));
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset rdata", bus_rdata, 0);
    chk_ser(0, 0, "R2 reset");
    brd(1, 10'h008, "R4 reset status");
    brd(2, 10'h000, "R5 reset enable");
    // R1: fill transmit queue, overrun write dropped
    for (int i = 0; i < DEPTH; i++) bwr(0, 10'(8'hA0 + i));
    bwr(0, 10'h0FF);
    brd(1, 10'h000, "R4 tx not empty");
    for (int i = 0; i < DEPTH; i++) begin
      idle(); chk_ser(1, 8'(8'hA0 + i), "R1 R2 drain order");
      spop();
    end
    idle(); chk_ser(0, 0, "R2 drained");
    brd(1, 10'h008, "R4 tx empty again");
    // R3: deserializer entries with flags
    dpush(8'h11, 1, 0); dpush(8'h22, 0, 1); dpush(8'h33, 0, 0);
    brd(1, 10'h00B, "R4 parity head");
    brd(0, 10'h011, "R3 read 1");
    brd(1, 10'h00D, "R4 framing head");
    brd(0, 10'h022, "R3 read 2");
    brd(1, 10'h009, "R4 clean head");
    brd(0, 10'h033, "R3 read 3");
    brd(0, 10'h000, "R9 empty read");
    brd(1, 10'h008, "R9 empty status");
    // R9: receive overrun
    for (int i = 0; i < DEPTH; i++) dpush(8'(8'h50 + i), 0, 0);
    dpush(8'hEE, 1, 1);
    for (int i = 0; i < DEPTH; i++) brd(0, 10'(8'h50 + i), "R9 rx full order");
    brd(1, 10'h008, "R9 overrun dropped");
    // R8: inject ignored in normal mode
    bwr(4, 10'h3AA);
    brd(1, 10'h008, "R8 inject ignored normal");
    // R5: entering test mode empties both queues
    bwr(0, 10'h055); bwr(0, 10'h066); dpush(8'h77, 0, 0);
    bwr(2, 10'h001);
    brd(2, 10'h001, "R5 enable readback");
    brd(1, 10'h008, "R5 queues cleared on entry");
    idle(); chk_ser(0, 0, "R5 serializer idle");
    // R6: writes accepted, serializer blocked
    bwr(0, 10'h0C1); bwr(0, 10'h0C2);
    spop(); spop();
    idle(); chk_ser(0, 0, "R6 avail low in test");
    brd(1, 10'h000, "R6 tx kept");
    // R7: peek pops in test mode
    brd(3, 10'h0C1, "R7 peek 1");
    brd(3, 10'h0C2, "R7 peek 2");
    brd(1, 10'h008, "R7 tx emptied by peek");
    brd(3, 10'h000, "R7 peek empty");
    // R8: deserializer ignored, injection works
    dpush(8'h44, 1, 1);
    brd(1, 10'h008, "R8 des ignored in test");
    bwr(4, 10'h2AB);
    brd(1, 10'h00D, "R8 inject framing");
    brd(0, 10'h0AB, "R8 inject data");
    bwr(4, 10'h1CD);
    brd(1, 10'h00B, "R8 inject parity");
    brd(0, 10'h0CD, "R8 inject data 2");
    // R5: leaving test mode clears, same-value write does not
    bwr(0, 10'h099);
    bwr(2, 10'h000);
    brd(2, 10'h000, "R5 enable cleared");
    brd(1, 10'h008, "R5 queues cleared on exit");
    bwr(0, 10'h012);
    bwr(2, 10'h000);
    idle(); chk_ser(1, 8'h12, "R5 same-value write keeps data");
    // R7: peek in normal mode does not pop
    brd(3, 10'h012, "R7 normal peek");
    idle(); chk_ser(1, 8'h12, "R7 normal peek no pop");
    // R10: rdata holds without reads
    idle(); idle();
    check("R10 rdata hold", bus_rdata, 10'h012);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    idle(); idle();
    if (exp_q.size() != 0) check("R10 pending reads", 10'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule